// File: doc/BRIEF.md
# Dynamic 32/16-bit Bus Sizing Unit

This unit sits between one internal doubleword transfer request and an external data bus whose width is learned only when each bus cycle is acknowledged. Every cycle begins as if the bus were 32 bits wide. The bus-size input is looked at only on the clock where the ready acknowledge is sampled. If that sample reports a 16-bit bus and upper bytes are part of the request, the unit asks the bus sequencer for one follow-up cycle. That cycle uses the same address. Its low two byte enables are forced off, and the upper half of the operand is moved onto the low data lanes.

For reads, the low half returned by the first 16-bit cycle is held in a register. It is joined with the half returned by the follow-up cycle before the completion flag rises. While a follow-up cycle is still owed, the unit tells the sequencer that a hold request must not be granted yet. Once the next-address input has been sampled asserted within a cycle, that cycle is taken to be 32 bits wide and no split takes place.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `busy`, `extra_cyc` and `xfer_done` are 0, `hold_ok` is 1 and `xfer_rdata` is 0.
- R2: A `req_load` while idle captures the request. From the next clock, `busy` is 1, `bus_be` equals the request byte enables (bit n enables byte n, active high) and `bus_wdata` equals the full 32-bit write data.
- R3: If `size16` is 0 on the acknowledging clock of the first cycle, the transfer ends there. `busy` falls and `xfer_done` pulses for one clock after that edge, with `xfer_rdata` equal to `bus_rdata` of that clock.
- R4: If `size16` is 1, `na_seen` is 0 and byte enable 2 or 3 is set on the first acknowledge, a follow-up cycle starts. `extra_cyc` is 1, `bus_be` is {be[3], be[2], 0, 0} and `xfer_done` stays 0.
- R5: If `size16` is 1 but byte enables 2 and 3 are both clear, the transfer completes in one cycle, as in R3.
- R6: If `na_seen` is 1 on the first acknowledge, the cycle is treated as 32-bit whatever `size16` is, and no follow-up cycle occurs.
- R7: During the follow-up cycle, both `bus_wdata[15:0]` and `bus_wdata[31:16]` carry request bits 31:16.
- R8: On the follow-up acknowledge, `xfer_rdata[15:0]` is `bus_rdata[15:0]` from the first acknowledge. `xfer_rdata[31:16]` is `bus_rdata[15:0]` of the follow-up acknowledge when `size16` is 1 there, and `bus_rdata[31:16]` when it is 0.
- R9: `hold_ok` is 0 from the split edge until the follow-up cycle is acknowledged, and 1 otherwise.
- R10: `ack` while idle, and `req_load` while busy, change nothing visible at the outputs.
- R11: Clocks without `ack` (wait states) in either cycle leave `bus_be`, `bus_wdata`, `extra_cyc` and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_load | input | 1 | Start of a new transfer (accepted only when idle) |
| req_be | input | 4 | Requested byte enables, bit n for byte n |
| req_wdata | input | 32 | Write data of the request |
| ack | input | 1 | Ready acknowledge sampled for the current cycle |
| size16 | input | 1 | Bus-size sample taken with ack: 1 = 16-bit, 0 = 32-bit |
| na_seen | input | 1 | Next address was sampled asserted in the current cycle |
| bus_rdata | input | 32 | Data pins on the acknowledging clock |
| bus_be | output | 4 | Byte enables for the current cycle |
| bus_wdata | output | 32 | Lane-steered write data |
| extra_cyc | output | 1 | A follow-up 16-bit cycle is in progress or owed |
| hold_ok | output | 1 | A hold request may be granted |
| busy | output | 1 | A transfer is in progress |
| xfer_rdata | output | 32 | Assembled read data |
| xfer_done | output | 1 | One-clock completion pulse |

## Verification
The bench targets the edges of the split decision. These are a 16-bit report with only the low enables set, a 16-bit report with only the upper enables set, and next-address arriving together with a 16-bit report. A design that got these wrong would add a needless cycle, drop the upper bytes, or split a cycle that is already committed. It also acknowledges the follow-up cycle with the size input negated. A unit that still takes the upper half from the low lanes there would return corrupted upper bytes. Wait states, stray acknowledges while idle and loads while busy are mixed in at random. These catch a design that lets the saved low half, the steered lanes or the hold permission drift between acknowledges.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/bus_size_decide.sv
module bus_size_decide #(
  parameter int BE_W = 4
) (
  input  logic [BE_W-1:0] be,
  input  logic            size16,
  input  logic            na_seen,
  output logic            need_second
);
  localparam int HALF_BE = BE_W / 2;

  function automatic logic split_needed(input logic [BE_W-1:0] e,
                                        input logic s16, input logic na);
    return s16 && !na && (|e[BE_W-1:HALF_BE]);
  endfunction

  assign need_second = split_needed(be, size16, na_seen);
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer #(
  parameter int HALF_W = 16
) (
  input  logic [(2*HALF_W/8)-1:0] be_q,
  input  logic [2*HALF_W-1:0]     wd_q,
  input  logic                    second,
  output logic [(2*HALF_W/8)-1:0] bus_be,
  output logic [2*HALF_W-1:0]     bus_wdata
);
  localparam int WORD_W  = 2 * HALF_W;
  localparam int BE_W    = WORD_W / 8;
  localparam int HALF_BE = BE_W / 2;

  genvar g;
  generate
    for (g = 0; g < BE_W; g++) begin : g_be
      if (g < HALF_BE) begin : g_low
        assign bus_be[g] = be_q[g] & ~second;
      end else begin : g_high
        assign bus_be[g] = be_q[g];
      end
    end
  endgenerate

  assign bus_wdata[WORD_W-1:HALF_W] = wd_q[WORD_W-1:HALF_W];
  assign bus_wdata[HALF_W-1:0]      = second ? wd_q[WORD_W-1:HALF_W]
                                             : wd_q[HALF_W-1:0];

  always_comb begin
    if (second) begin
      assert (bus_wdata[HALF_W-1:0] == bus_wdata[WORD_W-1:HALF_W]); // R7
    end
  end
endmodule

// File: rtl/bus_read_merge.sv
module bus_read_merge #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_low,
  input  logic                finish,
  input  logic                second,
  input  logic                size16,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic [2*HALF_W-1:0] xfer_rdata,
  output logic                xfer_done
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] low_q;

  function automatic logic [HALF_W-1:0] upper_pick(input logic [WORD_W-1:0] d,
                                                   input logic s16);
    return s16 ? d[HALF_W-1:0] : d[WORD_W-1:HALF_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q      <= '0;
      xfer_rdata <= '0;
      xfer_done  <= 1'b0;
    end else begin
      xfer_done <= finish;
      if (cap_low) low_q <= bus_rdata[HALF_W-1:0];
      if (finish) begin
        if (second) xfer_rdata <= {upper_pick(bus_rdata, size16), low_q};
        else        xfer_rdata <= bus_rdata;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R3

  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (second && !cap_low) |=> $stable(low_q)); // R8
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_load,
  input  logic [(2*HW/8)-1:0]   req_be,
  input  logic [2*HW-1:0]       req_wdata,
  input  logic                  ack,
  input  logic                  size16,
  input  logic                  na_seen,
  input  logic [2*HW-1:0]       bus_rdata,
  output logic [(2*HW/8)-1:0]   bus_be,
  output logic [2*HW-1:0]       bus_wdata,
  output logic                  extra_cyc,
  output logic                  hold_ok,
  output logic                  busy,
  output logic [2*HW-1:0]       xfer_rdata,
  output logic                  xfer_done
);
  localparam int WW = 2 * HW;
  localparam int BW = WW / 8;

  phase_e          phase;
  logic [BW-1:0]   be_q;
  logic [WW-1:0]   wd_q;
  logic            need_second;

  // Named internal events for the assertions
  logic first_ack, split_ev, finish_ev, accept_ev, in_second;

  assign in_second = (phase == PH_SECOND);
  assign busy      = (phase != PH_IDLE);
  assign accept_ev = req_load && (phase == PH_IDLE);
  assign first_ack = ack && (phase == PH_FIRST);
  assign split_ev  = first_ack && need_second;
  assign finish_ev = (first_ack && !need_second) || (ack && in_second);
  assign extra_cyc = in_second;
  assign hold_ok   = !in_second;

  bus_size_decide #(.BE_W(BW)) u_decide (
    .be          (be_q),
    .size16      (size16),
    .na_seen     (na_seen),
    .need_second (need_second)
  );

  bus_lane_steer #(.HALF_W(HW)) u_steer (
    .be_q      (be_q),
    .wd_q      (wd_q),
    .second    (in_second),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata)
  );

  bus_read_merge #(.HALF_W(HW)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_low    (split_ev),
    .finish     (finish_ev),
    .second     (in_second),
    .size16     (size16),
    .bus_rdata  (bus_rdata),
    .xfer_rdata (xfer_rdata),
    .xfer_done  (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      be_q  <= '0;
      wd_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (req_load) begin
          phase <= PH_FIRST;
          be_q  <= req_be;
          wd_q  <= req_wdata;
        end
        PH_FIRST: if (ack) phase <= need_second ? PH_SECOND : PH_IDLE;
        PH_SECOND: if (ack) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (busy && !extra_cyc)); // R2

  AST_WIDE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && !size16) |=> (!busy && xfer_done)); // R3

  AST_SPLIT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && size16 && !na_seen && (|be_q[BW-1:BW/2])) |=> (extra_cyc && !xfer_done)); // R4

  AST_NA_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && na_seen) |=> !extra_cyc); // R6

  AST_LOW_BE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cyc |-> (bus_be[BW/2-1:0] == '0)); // R4

  AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cyc |-> !hold_ok); // R9

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ack && !req_load) |=> (!busy && !xfer_done)); // R10

  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> ($stable(bus_be) && $stable(bus_wdata) && $stable(extra_cyc) && busy)); // R11
endmodule

// File: tb/bus_sizer_tb_top.sv
module bus_sizer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_load = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        ack = 1'b0;
  logic        size16 = 1'b0;
  logic        na_seen = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        extra_cyc, hold_ok, busy, xfer_done;
  logic [31:0] xfer_rdata;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sizer dut_i (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_be(req_be),
    .req_wdata(req_wdata), .ack(ack), .size16(size16), .na_seen(na_seen),
    .bus_rdata(bus_rdata), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .extra_cyc(extra_cyc), .hold_ok(hold_ok), .busy(busy),
    .xfer_rdata(xfer_rdata), .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the split rule
  function automatic bit model_split(input logic [3:0] be, input bit s16, input bit na);
    if (na) return 1'b0;
    if (!s16) return 1'b0;
    return (be[3] | be[2]);
  endfunction

  function automatic logic [31:0] model_merge(input logic [31:0] first_d,
                                              input logic [31:0] second_d, input bit s16b);
    logic [15:0] hi;
    hi = s16b ? second_d[15:0] : second_d[31:16];
    return {hi, first_d[15:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_xfer(input logic [3:0] be, input logic [31:0] wd,
                          input int w1, input bit s16a, input bit na,
                          input logic [31:0] rd1, input int w2,
                          input bit s16b, input logic [31:0] rd2,
                          input bit stray_load);
    bit sp;
    sp = model_split(be, s16a, na);
    req_be = be; req_wdata = wd; req_load = 1'b1;
    tick();
    req_load = 1'b0; req_be = ~be; req_wdata = ~wd;
    chk("R2 busy", {31'd0, busy}, 32'd1);
    chk("R2 be", {28'd0, bus_be}, {28'd0, be});
    chk("R2 wdata", bus_wdata, wd);
    for (int i = 0; i < w1; i++) begin
      if (stray_load && i == 0) req_load = 1'b1;
      tick();
      req_load = 1'b0;
      chk("R11 R10 first wait be", {28'd0, bus_be}, {28'd0, be});
      chk("R11 first wait wdata", bus_wdata, wd);
      chk("R11 first wait busy", {30'd0, busy, extra_cyc}, 32'd2);
    end
    ack = 1'b1; size16 = s16a; na_seen = na; bus_rdata = rd1;
    tick();
    ack = 1'b0; size16 = $urandom_range(0, 1); na_seen = $urandom_range(0, 1);
    bus_rdata = $urandom;
    if (!sp) begin
      chk((s16a && !na) ? "R5 done" : (na ? "R6 done" : "R3 done"),
          {30'd0, busy, xfer_done}, 32'd1);
      chk("R3 rdata", xfer_rdata, rd1);
      chk("R6 no extra", {31'd0, extra_cyc}, 32'd0);
      chk("R9 hold_ok", {31'd0, hold_ok}, 32'd1);
    end else begin
      chk("R4 extra", {29'd0, extra_cyc, busy, xfer_done}, 32'd6);
      chk("R4 be", {28'd0, bus_be}, {28'd0, be[3], be[2], 2'b00});
      chk("R7 wdata", bus_wdata, {wd[31:16], wd[31:16]});
      chk("R9 hold blocked", {31'd0, hold_ok}, 32'd0);
      for (int i = 0; i < w2; i++) begin
        tick();
        chk("R11 second wait be", {28'd0, bus_be}, {28'd0, be[3], be[2], 2'b00});
        chk("R11 second wait", {30'd0, extra_cyc, hold_ok}, 32'd2);
      end
      ack = 1'b1; size16 = s16b; na_seen = 1'b0; bus_rdata = rd2;
      tick();
      ack = 1'b0; bus_rdata = $urandom;
      chk("R8 done", {29'd0, busy, extra_cyc, xfer_done}, 32'd1);
      chk("R8 merge", xfer_rdata, model_merge(rd1, rd2, s16b));
      chk("R9 hold released", {31'd0, hold_ok}, 32'd1);
    end
    tick();
    chk("R3 done pulse", {31'd0, xfer_done}, 32'd0);
  endtask

  task automatic idle_ack();
    logic [31:0] keep;
    keep = xfer_rdata;
    ack = 1'b1; size16 = 1'b1; bus_rdata = $urandom;
    tick();
    ack = 1'b0;
    chk("R10 idle ack", {30'd0, busy, xfer_done}, 32'd0);
    chk("R10 idle rdata", xfer_rdata, keep);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {28'd0, busy, extra_cyc, xfer_done, hold_ok}, 32'd1);
    chk("R1 reset rdata", xfer_rdata, 32'd0);
    rst_n = 1'b1;
    tick();
    // Directed corner cases
    run_xfer(4'b1111, 32'hA1B2C3D4, 0, 1'b0, 1'b0, 32'h11223344, 0, 1'b0, '0, 1'b0); // R3
    run_xfer(4'b0011, 32'h01020304, 1, 1'b1, 1'b0, 32'h55667788, 0, 1'b0, '0, 1'b0); // R5
    run_xfer(4'b1100, 32'hCAFEBABE, 0, 1'b1, 1'b0, 32'h0000BEEF, 2, 1'b1, 32'h9999F00D, 1'b0); // R4 R8
    run_xfer(4'b1111, 32'hDEADBEEF, 1, 1'b1, 1'b1, 32'h12345678, 0, 1'b0, '0, 1'b0); // R6
    run_xfer(4'b1110, 32'h76543210, 2, 1'b1, 1'b0, 32'hAAAA5555, 1, 1'b0, 32'h3C3CC3C3, 1'b1); // R8 R10
    idle_ack(); // R10
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] be;
      be = 4'($urandom_range(1, 15));
      if (($urandom % 8) == 0) idle_ack();
      run_xfer(be, $urandom, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               ($urandom % 4) == 0, $urandom, $urandom_range(0, 3),
               1'($urandom_range(0, 1)), $urandom, ($urandom % 5) == 0);
    end
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule